// File: doc/BRIEF.md
# Two-Level PUF Authentication Decision Machine

This block decides, in two steps, whether a device and then one of its IP cores are genuine. It uses values taken from two physical unclonable functions. In the first step an evaluate strobe presents a Hamming-distance figure and an occurrence count, both derived from a strong-PUF response. The pair is looked up in a small table of programmable entries. A hit moves the machine into a chip-identity state that remembers which entry matched. A miss sends the machine directly to the unauthenticated verdict.

In the second step, a 16-bit key produced by a weak PUF is presented with a valid strobe. It is compared against the key that the designer stored in the selected entry. The comparison yields the authenticated or the unauthenticated verdict. That verdict is held and shown on two indicator outputs until a restart or a new evaluate strobe brings the machine back to its start state.

No challenge-response database is stored: the table holds only distance bounds, counts and keys. Each entry's distance test is either an exact value (low bound equal to high bound) or an inclusive range. The key-check result is a Mealy output, valid in the same cycle the key is presented.

Top module: `puf_auth_fsm`

## Requirements
- R1: After reset, or one cycle after a synchronous restart, state_o is START (code 0), and both indicators and key_ok_o are low.
- R2: In START, an evaluate strobe whose HD lies within [low, high] of an enabled entry, and whose OC equals that entry's count, moves the machine to SELECTED (code 1) on the next cycle. sel_idx_o then shows that entry's index.
- R3: An entry whose low bound equals its high bound matches only that exact HD value (for example, 9 matches but 8 and 10 do not).
- R4: When several enabled entries match, the lowest index is selected.
- R5: In START, an evaluate strobe that matches no entry moves the machine straight to DENIED (code 3).
- R6: In SELECTED, a key strobe whose key equals the selected entry's key raises key_ok_o in that same cycle and moves the machine to GRANTED (code 2) on the next cycle.
- R7: In SELECTED, a key strobe with any other key keeps key_ok_o low and moves the machine to DENIED.
- R8: GRANTED and DENIED hold while no evaluate strobe or restart arrives. A key strobe in START, GRANTED or DENIED has no effect. An evaluate strobe in SELECTED, GRANTED or DENIED returns the machine to START on the next cycle.
- R9: led_auth_o is high exactly in GRANTED, and led_unauth_o is high exactly in DENIED.
- R10: An entry whose enable bit is low never matches, whatever its bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | Synchronous return to START |
| eval_i | input | 1 | Evaluate strobe for the level-one lookup |
| hd_i | input | HD_W | Hamming-distance figure from the strong PUF |
| oc_i | input | OC_W | Occurrence count from the strong PUF |
| key_vld_i | input | 1 | Weak-PUF key strobe |
| key_i | input | KEY_W | Weak-PUF key |
| cfg_en_i | input | N_ENTRIES | Per-entry enable |
| cfg_hd_lo_i | input | N_ENTRIES*HD_W | Per-entry HD low bounds, entry i at bits i*HD_W |
| cfg_hd_hi_i | input | N_ENTRIES*HD_W | Per-entry HD high bounds |
| cfg_oc_i | input | N_ENTRIES*OC_W | Per-entry occurrence counts |
| cfg_key_i | input | N_ENTRIES*KEY_W | Per-entry expected keys |
| state_o | output | 2 | 0 START, 1 SELECTED, 2 GRANTED, 3 DENIED |
| sel_idx_o | output | IDX_W | Index of the entry chosen by level one |
| key_ok_o | output | 1 | Mealy key-match result during a key strobe in SELECTED |
| led_auth_o | output | 1 | Authenticated indicator |
| led_unauth_o | output | 1 | Unauthenticated indicator |

## Verification
The assertions check the following on every cycle: that a verdict state holds without a strobe, that a restart always lands in START, that a level-one hit taken in START leads to SELECTED, that key_ok_o only appears during a key strobe in SELECTED, and that the two indicators never light together. Only the bench scenarios can show which entry is chosen for a given (HD, OC) pair. The same holds for exact versus range matching, lowest-index priority among overlapping entries, disabled entries being skipped, and the verdict that follows a correct or a wrong key. To show these, the bench sweeps HD across 0 to 15 against six occurrence counts and predicts each outcome from its own copy of the table.

// File: rtl/puf_auth_pkg.sv
package puf_auth_pkg;

    typedef enum logic [1:0] {
        ST_START    = 2'd0,
        ST_SELECTED = 2'd1,
        ST_GRANTED  = 2'd2,
        ST_DENIED   = 2'd3
    } auth_state_e;

endpackage

// File: rtl/puf_lvl1_match.sv
module puf_lvl1_match #(
    parameter int N_ENTRIES = 8,
    parameter int HD_W      = 8,
    parameter int OC_W      = 8,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [HD_W-1:0]           hd_i,
    input  logic [OC_W-1:0]           oc_i,
    input  logic [N_ENTRIES-1:0]      cfg_en_i,
    input  logic [N_ENTRIES*HD_W-1:0] cfg_hd_lo_i,
    input  logic [N_ENTRIES*HD_W-1:0] cfg_hd_hi_i,
    input  logic [N_ENTRIES*OC_W-1:0] cfg_oc_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o
);

    logic [N_ENTRIES-1:0] hit_vec;

    // One comparator set per table entry
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        logic [HD_W-1:0] lo_w;
        logic [HD_W-1:0] hi_w;
        logic [OC_W-1:0] oc_w;
        assign lo_w = cfg_hd_lo_i[g*HD_W +: HD_W];
        assign hi_w = cfg_hd_hi_i[g*HD_W +: HD_W];
        assign oc_w = cfg_oc_i[g*OC_W +: OC_W];
        assign hit_vec[g] = cfg_en_i[g] && (hd_i >= lo_w) && (hd_i <= hi_w)
                            && (oc_i == oc_w);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        idx_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        hit_o = |hit_vec;
    end

endmodule

// File: rtl/puf_key_cmp.sv
module puf_key_cmp #(
    parameter int N_ENTRIES = 8,
    parameter int KEY_W     = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [IDX_W-1:0]           sel_idx_i,
    input  logic [N_ENTRIES*KEY_W-1:0] cfg_key_i,
    input  logic [KEY_W-1:0]           key_i,
    output logic                       match_o
);

    logic [KEY_W-1:0] expect_key;

    always_comb begin
        expect_key = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (sel_idx_i == IDX_W'(i)) begin
                expect_key = cfg_key_i[i*KEY_W +: KEY_W];
            end
        end
        match_o = (expect_key == key_i);
    end

endmodule

// File: rtl/puf_auth_fsm.sv
module puf_auth_fsm
    import puf_auth_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int HD_W      = 8,
    parameter int OC_W      = 8,
    parameter int KEY_W     = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       restart_i,
    input  logic                       eval_i,
    input  logic [HD_W-1:0]            hd_i,
    input  logic [OC_W-1:0]            oc_i,
    input  logic                       key_vld_i,
    input  logic [KEY_W-1:0]           key_i,
    input  logic [N_ENTRIES-1:0]       cfg_en_i,
    input  logic [N_ENTRIES*HD_W-1:0]  cfg_hd_lo_i,
    input  logic [N_ENTRIES*HD_W-1:0]  cfg_hd_hi_i,
    input  logic [N_ENTRIES*OC_W-1:0]  cfg_oc_i,
    input  logic [N_ENTRIES*KEY_W-1:0] cfg_key_i,
    output logic [1:0]                 state_o,
    output logic [IDX_W-1:0]           sel_idx_o,
    output logic                       key_ok_o,
    output logic                       led_auth_o,
    output logic                       led_unauth_o
);

    typedef struct packed {
        auth_state_e      st;
        logic [IDX_W-1:0] idx;
    } regs_t;

    regs_t            cur_q;
    regs_t            nxt_d;
    logic             lvl1_hit;
    logic [IDX_W-1:0] lvl1_idx;
    logic             key_match;
    logic             key_ok_d;

    puf_lvl1_match #(
        .N_ENTRIES (N_ENTRIES),
        .HD_W      (HD_W),
        .OC_W      (OC_W)
    ) lvl1_i (
        .hd_i        (hd_i),
        .oc_i        (oc_i),
        .cfg_en_i    (cfg_en_i),
        .cfg_hd_lo_i (cfg_hd_lo_i),
        .cfg_hd_hi_i (cfg_hd_hi_i),
        .cfg_oc_i    (cfg_oc_i),
        .hit_o       (lvl1_hit),
        .idx_o       (lvl1_idx)
    );

    puf_key_cmp #(
        .N_ENTRIES (N_ENTRIES),
        .KEY_W     (KEY_W)
    ) key_i_cmp (
        .sel_idx_i (cur_q.idx),
        .cfg_key_i (cfg_key_i),
        .key_i     (key_i),
        .match_o   (key_match)
    );

    always_comb begin
        nxt_d    = cur_q;
        key_ok_d = 1'b0;
        if (restart_i) begin
            nxt_d.st  = ST_START;
            nxt_d.idx = '0;
        end else begin
            unique case (cur_q.st)
                ST_START: begin
                    if (eval_i) begin
                        if (lvl1_hit) begin
                            nxt_d.st  = ST_SELECTED;
                            nxt_d.idx = lvl1_idx;
                        end else begin
                            nxt_d.st = ST_DENIED;
                        end
                    end
                end
                ST_SELECTED: begin
                    if (eval_i) begin
                        nxt_d.st = ST_START;
                    end else if (key_vld_i) begin
                        key_ok_d = key_match;
                        nxt_d.st = key_match ? ST_GRANTED : ST_DENIED;
                    end
                end
                default: begin
                    if (eval_i) begin
                        nxt_d.st = ST_START;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= ST_START;
            cur_q.idx <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o      = cur_q.st;
    assign sel_idx_o    = cur_q.idx;
    assign key_ok_o     = key_ok_d;
    assign led_auth_o   = (cur_q.st == ST_GRANTED);
    assign led_unauth_o = (cur_q.st == ST_DENIED);

    assert_restart_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cur_q.st == ST_START));

    assert_hit_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_START && eval_i && !restart_i && lvl1_hit)
        |=> (cur_q.st == ST_SELECTED));

    assert_keyok_context_R6: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok_o |-> (cur_q.st == ST_SELECTED && key_vld_i && !restart_i));

    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_GRANTED || cur_q.st == ST_DENIED) && !eval_i && !restart_i)
        |=> (cur_q.st == $past(cur_q.st)));

    assert_led_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_auth_o && led_unauth_o));

endmodule

// File: tb/puf_auth_fsm_tb.sv
module puf_auth_fsm_tb_top;

    localparam int N     = 8;
    localparam int HD_W  = 8;
    localparam int OC_W  = 8;
    localparam int KEY_W = 16;
    localparam int IDX_W = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 restart_i = 1'b0;
    logic                 eval_i = 1'b0;
    logic [HD_W-1:0]      hd_i = '0;
    logic [OC_W-1:0]      oc_i = '0;
    logic                 key_vld_i = 1'b0;
    logic [KEY_W-1:0]     key_i = '0;
    logic [N-1:0]         cfg_en_i;
    logic [N*HD_W-1:0]    cfg_hd_lo_i;
    logic [N*HD_W-1:0]    cfg_hd_hi_i;
    logic [N*OC_W-1:0]    cfg_oc_i;
    logic [N*KEY_W-1:0]   cfg_key_i;
    logic [1:0]           state_o;
    logic [IDX_W-1:0]     sel_idx_o;
    logic                 key_ok_o;
    logic                 led_auth_o;
    logic                 led_unauth_o;

    int n_chk = 0;
    int n_bad = 0;

    int t_en [N];
    int t_lo [N];
    int t_hi [N];
    int t_oc [N];
    int t_key[N];

    always #4 clk = ~clk;

    puf_auth_fsm #(.N_ENTRIES(N), .HD_W(HD_W), .OC_W(OC_W), .KEY_W(KEY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .eval_i(eval_i),
        .hd_i(hd_i), .oc_i(oc_i), .key_vld_i(key_vld_i), .key_i(key_i),
        .cfg_en_i(cfg_en_i), .cfg_hd_lo_i(cfg_hd_lo_i), .cfg_hd_hi_i(cfg_hd_hi_i),
        .cfg_oc_i(cfg_oc_i), .cfg_key_i(cfg_key_i), .state_o(state_o),
        .sel_idx_o(sel_idx_o), .key_ok_o(key_ok_o), .led_auth_o(led_auth_o),
        .led_unauth_o(led_unauth_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input int hd, input int oc);
        for (int i = 0; i < N; i++) begin
            if (t_en[i] != 0 && hd >= t_lo[i] && hd <= t_hi[i] && oc == t_oc[i]) begin
                return i;
            end
        end
        return -1;
    endfunction

    task automatic pulse_eval();
        @(negedge clk); eval_i = 1'b1;
        @(negedge clk); eval_i = 1'b0;
    endtask

    task automatic scenario(input int hd, input int oc);
        int e;
        string tag;
        bit good;
        // restart and confirm start state
        @(negedge clk); restart_i = 1'b1;
        @(negedge clk); restart_i = 1'b0;
        chk("R1 state after restart", state_o, 0);
        chk("R1 leds after restart", {led_auth_o, led_unauth_o}, 0);
        // key strobe in START is ignored
        @(negedge clk); key_vld_i = 1'b1; key_i = 16'hFEFE;
        @(negedge clk); key_vld_i = 1'b0;
        chk("R8 key ignored in START", state_o, 0);
        // level one
        e = exp_idx(hd, oc);
        if (oc == 20)                          tag = "R10";
        else if (oc == 14)                     tag = "R3";
        else if (oc == 3 && hd >= 1 && hd <= 6) tag = "R4";
        else if (e < 0)                        tag = "R5";
        else                                   tag = "R2";
        hd_i = HD_W'(hd); oc_i = OC_W'(oc);
        pulse_eval();
        if (e < 0) begin
            chk({tag, " miss goes to DENIED"}, state_o, 3);
            chk("R9 unauth led on miss", {led_auth_o, led_unauth_o}, 1);
        end else begin
            chk({tag, " hit goes to SELECTED"}, state_o, 1);
            chk({tag, " selected index"}, sel_idx_o, e);
            if (hd % 4 == 3) begin
                pulse_eval();
                chk("R8 eval in SELECTED returns START", state_o, 0);
                return;
            end
            good = ((hd + oc) % 2) == 0;
            @(negedge clk); key_vld_i = 1'b1;
            key_i = good ? KEY_W'(t_key[e]) : KEY_W'(t_key[e] ^ 16'h0100);
            #1;
            if (good) chk("R6 Mealy key_ok on match", key_ok_o, 1);
            else      chk("R7 key_ok low on mismatch", key_ok_o, 0);
            @(negedge clk); key_vld_i = 1'b0;
            if (good) begin
                chk("R6 GRANTED after good key", state_o, 2);
                chk("R9 auth led", {led_auth_o, led_unauth_o}, 2);
            end else begin
                chk("R7 DENIED after bad key", state_o, 3);
                chk("R9 unauth led", {led_auth_o, led_unauth_o}, 1);
            end
        end
        // verdict holds; key strobe ignored
        @(negedge clk); key_vld_i = 1'b1; key_i = KEY_W'(t_key[(e < 0) ? 0 : e]);
        @(negedge clk); key_vld_i = 1'b0;
        chk("R8 verdict holds", state_o, (e < 0 || !good) ? 3 : 2);
        pulse_eval();
        chk("R8 eval in verdict returns START", state_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ocs[6] = '{3, 8, 14, 17, 20, 5};
        // table: exact, exact, exact, range, overlapping range, disabled wide entry
        t_en  = '{1, 1, 1, 1, 1, 0, 0, 0};
        t_lo  = '{7, 8, 9, 1, 3, 0, 0, 0};
        t_hi  = '{7, 8, 9, 5, 6, 255, 0, 0};
        t_oc  = '{8, 17, 14, 3, 3, 20, 0, 0};
        t_key = '{16'h1111, 16'h2222, 16'hFEFE, 16'hA5A5, 16'h5A5A, 16'h7777, 0, 0};
        for (int i = 0; i < N; i++) begin
            cfg_en_i[i]                  = (t_en[i] != 0);
            cfg_hd_lo_i[i*HD_W +: HD_W]  = HD_W'(t_lo[i]);
            cfg_hd_hi_i[i*HD_W +: HD_W]  = HD_W'(t_hi[i]);
            cfg_oc_i[i*OC_W +: OC_W]     = OC_W'(t_oc[i]);
            cfg_key_i[i*KEY_W +: KEY_W]  = KEY_W'(t_key[i]);
        end
        repeat (3) @(negedge clk);
        chk("R1 reset state", state_o, 0);
        chk("R1 reset key_ok", key_ok_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {led_auth_o, led_unauth_o}, 0);
        for (int h = 0; h < 16; h++) begin
            for (int k = 0; k < 6; k++) begin
                scenario(h, ocs[k]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule